// File: doc/BRIEF.md
# Dotting and Sync Audio-Mute Detector

This block watches a recovered serial bit stream, taking one bit on each cycle in which a bit-valid strobe is high. It looks for two conditions that announce a data burst on a voice channel. The first is a run of alternating bits that runs straight into the 11-bit synchronization word. The second is two synchronization words whose last bits lie exactly 77 bit periods apart. When either condition is seen, the block pulls an active-low mute line low so that the audio path can be blanked. The mute line stays low until a host clear or a reset.

A polarity input lets the same block serve demodulators that deliver the stream in either sense. When the input is high, every bit is inverted before detection. A one-cycle sync-found pulse marks every match of the synchronization word, whether or not it leads to a mute.

Top module: `dsm_mute_detect`

## Requirements
- R1: When the 10 bits just before the synchronization word 11100010010 (first bit on the left) are alternating and the last of them is 0 (1010101010), the sample of the sync word's final bit drives mute_n from 1 to 0 at that same clock edge.
- R2: When two synchronization words end exactly 77 accepted bits apart, the sample of the second word's final bit drives mute_n to 0 at that edge.
- R3: Sync pairs that end 76 or 78 bits apart do not mute. Each new sync match restarts the spacing measurement, so a sync that falls inside the window cancels the earlier candidate.
- R4: Once mute_n is 0 it stays 0 until reset or mute_clr. A cycle with mute_clr high returns mute_n to 1 at the next edge. If a trigger occurs in the same cycle, the trigger wins.
- R5: sync_pulse is high for exactly the one cycle that follows the edge at which a sync word's final bit is accepted, whether or not dotting came before it.
- R6: When rx_invert is high, each received bit is inverted before detection. When it is low, bits are taken as received.
- R7: Cycles with bit_valid low add no bit. Idle cycles between bits have no effect on detection or spacing.
- R8: After reset, mute_n is 1 and sync_pulse is 0.
- R9: A sync word preceded by only 9 alternating bits does not mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe: rx_bit holds a new bit this cycle |
| rx_bit | input | 1 | Received data bit |
| rx_invert | input | 1 | 1 inverts the received stream, 0 takes it as received |
| mute_clr | input | 1 | Host clear of the latched mute |
| mute_n | output | 1 | Active-low audio mute, registered |
| sync_pulse | output | 1 | One-cycle pulse per sync word match, registered |

## Verification
The assertions assume that bit_valid and rx_bit are settled at each rising edge. They also assume that the default sync word cannot match itself when shifted by a single bit, which is why two pulses can never fall on adjacent cycles. The bench changes its inputs only on falling edges and raises the strobe for one cycle per bit, so these assumptions always hold. Between scenarios it applies reset, which empties the bit history so that no earlier bits can form a false sync or dotting window. Filler bits are zeros or ones of the inverted sense, and neither can form part of a match.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  // Alternating pattern with the newest bit (LSB) equal to 0.
  function automatic logic [63:0] alt_pattern(input int n);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < 64; i++)
      if (i < n) p[i] = i[0];
    return p;
  endfunction
endpackage

// File: rtl/dsm_history.sv
module dsm_history
  import dsm_pkg::*;
#(
  parameter int          SYNC_LEN = 11,
  parameter logic [10:0] SYNC_PAT = 11'b11100010010,
  parameter int          DOT_MIN  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic din,
  output logic sync_hit,
  output logic dot_hit
);
  localparam int HW = SYNC_LEN + DOT_MIN - 1;
  localparam logic [DOT_MIN-1:0] DOT_PAT = DOT_MIN'(alt_pattern(DOT_MIN));

  logic [HW-1:0]       hist;
  logic [SYNC_LEN-1:0] win;

  assign win      = {hist[SYNC_LEN-2:0], din};
  assign sync_hit = bit_valid && (win == SYNC_PAT);
  assign dot_hit  = sync_hit && (hist[HW-1:SYNC_LEN-1] == DOT_PAT);

  always_ff @(posedge clk) begin
    if (rst)            hist <= '0;
    else if (bit_valid) hist <= {hist[HW-2:0], din};
  end

  // R7: idle cycles leave the history untouched
  p_hist_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(hist));
endmodule

// File: rtl/dsm_spacing.sv
module dsm_spacing #(
  parameter int SYNC_GAP = 77
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic sync_hit,
  output logic pair_hit
);
  localparam int CW = $clog2(SYNC_GAP + 1);
  localparam logic [CW-1:0] LAST = CW'(SYNC_GAP - 1);

  logic          armed;
  logic [CW-1:0] cnt;

  assign pair_hit = sync_hit && armed && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (bit_valid) begin
      if (sync_hit) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (cnt == LAST) armed <= 1'b0;
        else             cnt   <= cnt + 1'b1;
      end
    end
  end

  // R3: an armed candidate never counts past the exact spacing
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt <= LAST));
  // R3: a candidate that reaches the window end without a match is dropped
  p_discard_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt == LAST && bit_valid && !sync_hit) |=> !armed);
endmodule

// File: rtl/dsm_mute_detect.sv
module dsm_mute_detect #(
  parameter int          SYNC_LEN = 11,
  parameter logic [10:0] SYNC_PAT = 11'b11100010010,
  parameter int          DOT_MIN  = 10,
  parameter int          SYNC_GAP = 77
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic rx_bit,
  input  logic rx_invert,
  input  logic mute_clr,
  output logic mute_n,
  output logic sync_pulse
);
  logic din, sync_hit, dot_hit, pair_hit, trig;

  assign din  = rx_bit ^ rx_invert;
  assign trig = dot_hit | pair_hit;

  dsm_history #(.SYNC_LEN(SYNC_LEN), .SYNC_PAT(SYNC_PAT), .DOT_MIN(DOT_MIN)) u_hist (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .din(din),
    .sync_hit(sync_hit), .dot_hit(dot_hit));

  dsm_spacing #(.SYNC_GAP(SYNC_GAP)) u_gap (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .sync_hit(sync_hit),
    .pair_hit(pair_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      mute_n     <= 1'b1;
      sync_pulse <= 1'b0;
    end else begin
      sync_pulse <= sync_hit;
      if (trig)          mute_n <= 1'b0;
      else if (mute_clr) mute_n <= 1'b1;
    end
  end

  // R4: a latched mute holds without a clear
  p_mute_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!mute_n && !mute_clr) |=> !mute_n);
  // R4: a clear without trigger releases the mute
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (mute_clr && !trig) |=> mute_n);
  // R5: a sync pulse follows an accepted bit and lasts one cycle
  p_pulse_vld_r5: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> $past(bit_valid));
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sync_pulse);
endmodule

// File: tb/test_dsm_mute_detect.sv
`timescale 1ns/1ps
module test_dsm_mute_detect;
  localparam logic [10:0] SW = 11'b11100010010;

  logic clk = 0, rst = 1, bit_valid = 0, rx_bit = 0, rx_invert = 0, mute_clr = 0;
  logic mute_n, sync_pulse;
  int checks = 0, fails = 0, pulse_err = 0, pulses = 0;
  logic [10:0] mh = '0;

  always #4 clk = ~clk;

  dsm_mute_detect i_dsm_mute_detect (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .rx_invert(rx_invert), .mute_clr(mute_clr), .mute_n(mute_n),
    .sync_pulse(sync_pulse));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle; inputs change on the falling edge, outputs sampled there too.
  task automatic cyc(input logic v, input logic b);
    logic ep;
    rx_bit = b; bit_valid = v;
    ep = v && ({mh[9:0], b ^ rx_invert} == SW);
    if (v) mh = {mh[9:0], b ^ rx_invert};
    @(negedge clk);
    bit_valid = 0;
    if (sync_pulse !== ep) pulse_err++;
    if (sync_pulse) pulses++;
  endtask

  task automatic send(input logic b, input int idle);
    cyc(1, b);
    for (int i = 0; i < idle; i++) cyc(0, 0);
  endtask

  task automatic fill(input int n, input logic b);
    for (int i = 0; i < n; i++) send(b, 0);
  endtask

  task automatic dots(input int n, input logic x, input int idle);
    for (int i = n - 1; i >= 0; i--) send(logic'(i % 2) ^ x, idle);
  endtask

  task automatic word(input logic x, input int idle);
    for (int i = 10; i >= 0; i--) send(SW[i] ^ x, idle);
  endtask

  // Sync word with a check that mute is still high before its last bit.
  task automatic word_split(input string req);
    for (int i = 10; i >= 1; i--) send(SW[i], 0);
    check(mute_n === 1'b1, req, mute_n, 1);
    send(SW[0], 0);
  endtask

  task automatic do_reset;
    rst = 1; mute_clr = 0; rx_invert = 0;
    cyc(0, 0); cyc(0, 0);
    rst = 0; mh = '0; pulses = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R8 reset state
    check(mute_n === 1'b1, "R8 mute_n", mute_n, 1);
    check(sync_pulse === 1'b0, "R8 sync_pulse", sync_pulse, 0);

    // R1 dotting then sync
    fill(3, 0); dots(10, 0, 0); word_split("R1 before last bit");
    check(mute_n === 1'b0, "R1 mute after sync", mute_n, 0);
    // R4 hold, then clear
    for (int i = 0; i < 50; i++) cyc(0, 0);
    fill(20, 0);
    check(mute_n === 1'b0, "R4 hold", mute_n, 0);
    mute_clr = 1; cyc(0, 0); mute_clr = 0;
    check(mute_n === 1'b1, "R4 clear", mute_n, 1);
    fill(20, 0);
    check(mute_n === 1'b1, "R4 stays clear", mute_n, 1);

    // R9 only 9 dotting bits; R5 pulse still seen
    do_reset(); fill(3, 0); dots(9, 0, 0); word(0, 0); fill(2, 0);
    check(mute_n === 1'b1, "R9 short dotting", mute_n, 1);
    check(pulses == 1, "R5 pulse without dotting", pulses, 1);

    // R2 spacing 77
    do_reset(); fill(3, 0); word(0, 0); fill(66, 0); word_split("R2 before last bit");
    check(mute_n === 1'b0, "R2 spacing 77", mute_n, 0);

    // R3 spacing 76 and 78
    do_reset(); fill(3, 0); word(0, 0); fill(65, 0); word(0, 0); fill(2, 0);
    check(mute_n === 1'b1, "R3 spacing 76", mute_n, 1);
    do_reset(); fill(3, 0); word(0, 0); fill(67, 0); word(0, 0); fill(2, 0);
    check(mute_n === 1'b1, "R3 spacing 78", mute_n, 1);
    // R3 intervening sync restarts the measurement
    do_reset(); fill(3, 0); word(0, 0); fill(30, 0); word(0, 0); fill(25, 0); word(0, 0);
    check(mute_n === 1'b1, "R3 restart", mute_n, 1);
    fill(66, 0); word(0, 0);
    check(mute_n === 1'b0, "R3 pair after restart", mute_n, 0);

    // R6 inverted polarity
    do_reset(); rx_invert = 1; fill(3, 1); dots(10, 1, 0); word(1, 0);
    check(mute_n === 1'b0, "R6 inverted stream", mute_n, 0);
    do_reset(); rx_invert = 1; fill(3, 1); dots(10, 0, 0); word(0, 0); fill(2, 1);
    check(mute_n === 1'b1, "R6 uninverted stream ignored", mute_n, 1);

    // R7 idle cycles between bits
    do_reset(); fill(3, 0); dots(10, 0, 3); word(0, 2);
    check(mute_n === 1'b0, "R7 idle gaps", mute_n, 0);
    check(pulses == 1, "R7 one pulse", pulses, 1);

    // R4 trigger wins over simultaneous clear
    do_reset(); fill(3, 0); dots(10, 0, 0);
    for (int i = 10; i >= 1; i--) send(SW[i], 0);
    mute_clr = 1; send(SW[0], 0); mute_clr = 0;
    check(mute_n === 1'b0, "R4 trigger beats clear", mute_n, 0);

    check(pulse_err == 0, "R5 pulse timing", pulse_err, 0);
    summary();
  end
endmodule